// File: doc/BRIEF.md
# Three-Wire Serial Character Display Controller

This block drives a character display through an external 8-bit serial-in, parallel-out shift register using three lines only: a serial data line, a shift clock and an enable strobe. A client hands over one byte at a time with a command/character flag through a valid/ready handshake. The block shifts the byte out most significant bit first. It then holds the shift clock at the register-select level while it pulses the strobe once, so the display latches the byte with the right register select even though there is no fourth wire.

After reset the block runs the display's power-up initialisation on its own: a long settling wait, then four setup commands, each followed by its required delay. A microsecond tick derived from the system clock frequency times every wait. A client can also ask for a cursor move to a line and column. The block turns that request into the matching position command.

Top module: `lcd3w_ctrl`

## Requirements
- R1: Each transfer sends exactly eight bits on `lcd_dat`, most significant bit first.
- R2: For each bit, `lcd_clk` is low for `PHASE_CYC` cycles and then high for `PHASE_CYC` cycles, and `lcd_dat` holds that bit for both phases.
- R3: After the eighth bit, `lcd_clk` carries the register-select level for 3×`PHASE_CYC` cycles: 0 for a command and 1 for character data. `lcd_dat` is 0 during those cycles.
- R4: Each transfer raises `lcd_stb` exactly once, for `PHASE_CYC` cycles, in the middle of the register-select window.
- R5: After reset, all three lines are 0 and `in_ready` is 0. After `PWRUP_US` microseconds the block sends the commands 0x38, 0x0C, 0x06 and 0x01, in that order.
- R6: After each byte, all lines are 0 for `BYTE_US` microseconds before anything else happens. The wait is `CLR_US` microseconds when the byte was the command 0x01. One microsecond is `CLK_HZ`/1,000,000 cycles.
- R7: `in_ready` is 1 only when no initialisation, transfer or wait is in progress. A byte is accepted only on a cycle with `in_valid` and `in_ready` both 1. While `in_ready` is 0, `in_valid` has no effect.
- R8: A request with `in_goto`=1 sends the command 0x80 + base + `in_col`, where base is 0x00, 0x40, 0x14 or 0x54 for `in_line` 0, 1, 2 or 3. `in_byte` and `in_rs` are ignored for such a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Client offers a byte or a cursor request |
| in_ready | output | 1 | Block can accept a request this cycle |
| in_byte | input | 8 | Byte to send when `in_goto` is 0 |
| in_rs | input | 1 | 1 = character data, 0 = command |
| in_goto | input | 1 | 1 = cursor move request, built from line and column |
| in_line | input | 2 | Display line for a cursor move |
| in_col | input | COL_W | Column for a cursor move |
| lcd_dat | output | 1 | Serial data to the shift register |
| lcd_clk | output | 1 | Shift clock; register-select level after the eighth bit |
| lcd_stb | output | 1 | Display enable strobe |

## Verification
A wrong phase or bit counter shows on `lcd_dat`/`lcd_clk` in the same cycle that it goes wrong: a bit comes out early, late or out of order, or the clock edge is misplaced. A wrong microsecond or wait count shows as a transfer or a rising `in_ready` that is off by at least one cycle. A wrong accept path shows only when the next transfer starts, with the wrong byte or register select. The bench compares all four outputs against a behavioural model on every cycle, so each of these errors is reported in the cycle where it first shows.

// File: rtl/lcd3w_pkg.sv
// Package: shared state types and command helpers for the three-wire
// display controller. Assumes a 7-bit display address space.
package lcd3w_pkg;

    typedef enum logic [2:0] {
        SH_IDLE, SH_LOW, SH_HIGH, SH_SETUP, SH_STB, SH_HOLD
    } sh_state_t;

    typedef enum logic [1:0] {
        ST_WAIT, ST_SEND, ST_IDLE
    } seq_state_t;

    localparam int unsigned INIT_LEN = 4;
    localparam logic [7:0]  CMD_CLEAR = 8'h01;

    // Start address of each display line (line 0..3).
    function automatic logic [6:0] line_base(input logic [1:0] line);
        case (line)
            2'd0:    return 7'h00;
            2'd1:    return 7'h40;
            2'd2:    return 7'h14;
            default: return 7'h54;
        endcase
    endfunction

    // Power-up command list; the order is the required sequence.
    function automatic logic [7:0] init_cmd(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h38;
            3'd1:    return 8'h0C;
            3'd2:    return 8'h06;
            default: return CMD_CLEAR;
        endcase
    endfunction

endpackage

// File: rtl/lcd3w_tick.sv
// Module: microsecond tick generator. Counts system clocks while run is
// high and pulses tick every DIV cycles. The count restarts from zero
// whenever run is low. Assumes CLK_HZ is a multiple of 1 MHz, at least 1 MHz.
module lcd3w_tick #(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned DIV = CLK_HZ / 1_000_000;
    localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    // Advance the divider, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcd3w_shifter.sv
// Module: serialiser for one byte. On start it loads the byte and the
// register-select flag. It shifts eight bits MSB first, each with a low and a
// high clock phase. It then drives the clock line with the select level for a
// setup, a strobe and a hold phase. Every phase lasts PHASE_CYC cycles. done
// pulses in the last cycle. Assumes start only while busy is low.
module lcd3w_shifter
    import lcd3w_pkg::*;
#(
    parameter int unsigned PHASE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_i,
    input  logic       rs_i,
    output logic       dat_o,
    output logic       sclk_o,
    output logic       stb_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int unsigned PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

    sh_state_t   st;
    logic [7:0]  sr;
    logic        rs_q;
    logic [2:0]  bit_cnt;
    logic [PW-1:0] pcnt;
    logic        last;

    assign last   = (pcnt == PW'(PHASE_CYC - 1));
    assign busy_o = (st != SH_IDLE);
    assign done_o = (st == SH_HOLD) && last;

    // Output lines decoded from the phase.
    always_comb begin
        dat_o  = (st == SH_LOW || st == SH_HIGH) ? sr[7] : 1'b0;
        stb_o  = (st == SH_STB);
        case (st)
            SH_HIGH:                  sclk_o = 1'b1;
            SH_SETUP, SH_STB, SH_HOLD: sclk_o = rs_q;
            default:                  sclk_o = 1'b0;
        endcase
    end

    // Phase sequencer: bit loop, then select/strobe window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            sr      <= '0;
            rs_q    <= 1'b0;
            bit_cnt <= '0;
            pcnt    <= '0;
        end else begin
            pcnt <= (st == SH_IDLE || last) ? '0 : pcnt + 1'b1;
            case (st)
                SH_IDLE: if (start) begin
                    sr      <= byte_i;
                    rs_q    <= rs_i;
                    bit_cnt <= '0;
                    st      <= SH_LOW;
                end
                SH_LOW:  if (last) st <= SH_HIGH;
                SH_HIGH: if (last) begin
                    if (bit_cnt == 3'd7) begin
                        st <= SH_SETUP;
                    end else begin
                        sr      <= {sr[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        st      <= SH_LOW;
                    end
                end
                SH_SETUP: if (last) st <= SH_STB;
                SH_STB:   if (last) st <= SH_HOLD;
                SH_HOLD:  if (last) st <= SH_IDLE;
                default:  st <= SH_IDLE;
            endcase
        end
    end

    // R2: data may not move across the rising clock edge of a bit.
    p_dat_stable_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SH_HIGH && pcnt == '0) |-> $stable(dat_o));
    // R3: while the strobe is high, the clock line carries the select level.
    p_clk_is_rs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |-> (sclk_o == rs_q && !dat_o));
    // R4: a strobe rise is always preceded by the setup phase.
    p_stb_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_o) |-> ($past(st) == SH_SETUP));
endmodule

// File: rtl/lcd3w_ctrl.sv
// Module: top of the three-wire display controller. It sequences the
// power-up wait and the init commands, then serves client requests with a
// valid/ready handshake. Cursor requests become position commands. After
// each byte it waits the settling time. Assumes BYTE_US, CLR_US >= 1 and
// both at most PWRUP_US.
module lcd3w_ctrl
    import lcd3w_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned PWRUP_US  = 100_000,
    parameter int unsigned CLR_US    = 2_000,
    parameter int unsigned BYTE_US   = 40,
    parameter int unsigned PHASE_CYC = 25,
    parameter int unsigned COL_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    input  logic             in_rs,
    input  logic             in_goto,
    input  logic [1:0]       in_line,
    input  logic [COL_W-1:0] in_col,
    output logic             lcd_dat,
    output logic             lcd_clk,
    output logic             lcd_stb
);
    localparam int unsigned TW = $clog2(PWRUP_US + 1);

    seq_state_t  state;
    logic [TW-1:0] wcnt;
    logic [TW-1:0] target;
    logic [2:0]  init_idx;
    logic        us_tick;
    logic        wdone;
    logic        sh_start, sh_busy, sh_done;
    logic [7:0]  sh_byte;
    logic        sh_rs;

    assign in_ready = (state == ST_IDLE);
    assign wdone    = (state == ST_WAIT) && us_tick && (wcnt == target - 1'b1);

    lcd3w_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_WAIT),
        .tick  (us_tick)
    );

    // Choose the next byte: init list, cursor command or client byte.
    always_comb begin
        sh_start = 1'b0;
        sh_byte  = init_cmd(init_idx);
        sh_rs    = 1'b0;
        if (state == ST_WAIT) begin
            sh_start = wdone && (init_idx < 3'(INIT_LEN));
        end else if (state == ST_IDLE) begin
            sh_start = in_valid;
            if (in_goto) begin
                sh_byte = {1'b1, line_base(in_line) + 7'(in_col)};
            end else begin
                sh_byte = in_byte;
                sh_rs   = in_rs;
            end
        end
    end

    lcd3w_shifter #(.PHASE_CYC(PHASE_CYC)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .byte_i (sh_byte),
        .rs_i   (sh_rs),
        .dat_o  (lcd_dat),
        .sclk_o (lcd_clk),
        .stb_o  (lcd_stb),
        .busy_o (sh_busy),
        .done_o (sh_done)
    );

    // Sequencer: wait -> send -> wait ..., then idle for the client.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT;
            target   <= TW'(PWRUP_US);
            wcnt     <= '0;
            init_idx <= '0;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (wdone) begin
                        wcnt <= '0;
                        if (sh_start) begin
                            init_idx <= init_idx + 1'b1;
                            state    <= ST_SEND;
                        end else begin
                            state    <= ST_IDLE;
                        end
                    end else if (us_tick) begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_IDLE: if (sh_start) state <= ST_SEND;
                ST_SEND: if (sh_done) state <= ST_WAIT;
                default: state <= ST_IDLE;
            endcase
            if (sh_start) begin
                target <= (!sh_rs && sh_byte == CMD_CLEAR) ? TW'(CLR_US) : TW'(BYTE_US);
            end
        end
    end

    // R7: ready only when the serialiser is free and the strobe is low.
    p_ready_line_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!sh_busy && !lcd_stb));
    // R7: an accepted request drops ready on the next cycle.
    p_accept_drops_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    // R6: the wait counter never passes its target.
    p_wait_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (wcnt < target));
    // R5: nothing is sent while the power-up wait or any wait runs.
    p_quiet_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (!lcd_dat && !lcd_clk && !lcd_stb));
endmodule

// File: tb/lcd3w_ctrl_tb.sv
// Bench: behavioural cycle model of the three lines and ready, compared on
// every clock against the design.
module lcd3w_ctrl_tb;
    localparam int unsigned CLK_HZ = 2_000_000;
    localparam int unsigned DIV    = CLK_HZ / 1_000_000;
    localparam int unsigned PWR    = 30;
    localparam int unsigned CLR    = 10;
    localparam int unsigned BYT    = 3;
    localparam int unsigned P      = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_rs = 1'b0, in_goto = 1'b0;
    logic [7:0] in_byte = '0;
    logic [1:0] in_line = '0;
    logic [4:0] in_col = '0;
    logic in_ready, lcd_dat, lcd_clk, lcd_stb;

    int checks = 0;
    int fails  = 0;

    logic e_dat = 1'b0, e_clk = 1'b0, e_stb = 1'b0, e_rdy = 1'b0;
    string e_tag = "R5";

    always #10 clk = ~clk;

    lcd3w_ctrl #(.CLK_HZ(CLK_HZ), .PWRUP_US(PWR), .CLR_US(CLR), .BYTE_US(BYT),
                 .PHASE_CYC(P), .COL_W(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_rs(in_rs), .in_goto(in_goto), .in_line(in_line),
        .in_col(in_col), .lcd_dat(lcd_dat), .lcd_clk(lcd_clk), .lcd_stb(lcd_stb)
    );

    // Cursor command expected for a line and column (R8).
    function automatic logic [7:0] goto_cmd(input logic [1:0] ln, input logic [4:0] col);
        int base;
        case (ln)
            2'd0: base = 'h00;
            2'd1: base = 'h40;
            2'd2: base = 'h14;
            default: base = 'h54;
        endcase
        return 8'(8'h80 + base + col);
    endfunction

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Expected waveform of one transfer plus its wait.
    task automatic m_send(input logic [7:0] b, input logic rs, input string btag);
        for (int i = 7; i >= 0; i--) begin
            e_tag = btag; e_dat = b[i]; e_stb = 1'b0;
            e_clk = 1'b0; hold(P);
            e_clk = 1'b1; hold(P);
        end
        e_tag = "R3"; e_dat = 1'b0; e_clk = rs; hold(P);
        e_tag = "R4"; e_stb = 1'b1; hold(P);
        e_tag = "R3"; e_stb = 1'b0; hold(P);
        e_tag = "R6"; e_clk = 1'b0;
        hold(DIV * ((!rs && b == 8'h01) ? CLR : BYT));
    endtask

    // Reference model process.
    initial begin
        wait (rst_n === 1'b1);
        e_tag = "R5";
        hold(DIV * PWR);
        m_send(8'h38, 1'b0, "R5");
        m_send(8'h0C, 1'b0, "R5");
        m_send(8'h06, 1'b0, "R5");
        m_send(8'h01, 1'b0, "R5");
        forever begin
            e_rdy = 1'b1; e_tag = "R7";
            do @(posedge clk); while (!in_valid);
            e_rdy = 1'b0;
            if (in_goto) m_send(goto_cmd(in_line, in_col), 1'b0, "R8");
            else         m_send(in_byte, in_rs, "R1/R2");
        end
    end

    task automatic cmp(input string sig, input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %b expected %b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the clock edge.
    initial begin
        forever begin
            @(negedge clk); #2;
            cmp("lcd_dat", lcd_dat, e_dat, e_tag);
            cmp("lcd_clk", lcd_clk, e_clk, e_tag);
            cmp("lcd_stb", lcd_stb, e_stb, e_tag);
            cmp("in_ready", in_ready, e_rdy, "R7");
        end
    end

    task automatic push(input logic [7:0] b, input logic rs, input logic go,
                        input logic [1:0] ln, input logic [4:0] col);
        @(negedge clk);
        in_byte = b; in_rs = rs; in_goto = go; in_line = ln; in_col = col;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // R7: offer a junk request while busy; it must not be taken.
    task automatic junk_while_busy();
        @(negedge clk);
        in_byte = 8'hE7; in_rs = 1'b1; in_goto = 1'b0; in_valid = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(8'hA5, 1'b1, 1'b0, 2'd0, 5'd0);        // R1 data byte
        junk_while_busy();                           // R7
        push(8'h5A, 1'b1, 1'b0, 2'd0, 5'd0);
        push(8'h00, 1'b0, 1'b0, 2'd0, 5'd0);        // R3 command level
        push(8'hFF, 1'b1, 1'b0, 2'd0, 5'd0);
        push(8'h01, 1'b0, 1'b0, 2'd0, 5'd0);        // R6 clear wait
        push(8'h01, 1'b1, 1'b0, 2'd0, 5'd0);        // R6 data 0x01: short wait
        push(8'h11, 1'b1, 1'b1, 2'd0, 5'd0);        // R8 line 0, byte ignored
        push(8'h22, 1'b0, 1'b1, 2'd1, 5'd3);        // R8 line 1
        junk_while_busy();
        push(8'h33, 1'b1, 1'b1, 2'd2, 5'd19);       // R8 line 2
        push(8'hFF, 1'b1, 1'b1, 2'd3, 5'd31);       // R8 line 3, last column
        while (!in_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule